// File: doc/BRIEF.md
# Registered 32-bit Integer Execution Unit

This block is the integer arithmetic and logic stage of a small load/store processor with 32 general registers. Each cycle it takes two 32-bit operands, a 5-bit constant shift count, a flag that picks where a shift count comes from, and a 4-bit operation code. It returns a 32-bit result and an overflow-trap flag one clock later. The operations are: add and subtract in a trapping form and a non-trapping form, four bitwise logic functions, signed and unsigned set-on-less-than, three shifts, and the placement of a 16-bit constant in the upper half of a word. Immediate forms use the same codes. The caller sign-extends or zero-extends the immediate onto operand B before it reaches the block.

The overflow flag is meant to start a trap in the surrounding pipeline. Only the trapping add and subtract codes can set it. Multiply, divide, the register file and instruction decode are outside this block.

Top module: `risc_alu`

## Requirements
- R1: Code 0 (trapping add) returns A+B modulo 2^32 and sets the overflow flag exactly when the signed sum does not fit in 32 bits.
- R2: Code 2 (trapping subtract) returns A-B modulo 2^32 and sets the overflow flag exactly when the signed difference does not fit in 32 bits.
- R3: Codes 1 (add) and 3 (subtract) return the same values as codes 0 and 2, and the overflow flag is always 0 for them.
- R4: Codes 4, 5, 6 and 7 return A AND B, A OR B, A XOR B and NOT(A OR B), bit by bit.
- R5: Code 8 returns 1 when A < B as two's-complement numbers and 0 otherwise. Bits 31:1 are 0. The answer is correct even when A-B would overflow.
- R6: Code 9 returns 1 when A < B as unsigned numbers and 0 otherwise. With A = 0xFFFFFFFF and B = 1, code 8 gives 1 and code 9 gives 0.
- R7: Codes 10, 11 and 12 shift operand B left with zero fill, right with zero fill, and right with copies of bit 31 (arithmetic).
- R8: When the amount-source input is 0, a shift uses the 5-bit constant input as its count. When it is 1, a shift uses A[4:0] as the count, and A[31:5] have no effect.
- R9: Code 13 returns B[15:0] in bits 31:16 and zeros in bits 15:0. B[31:16] have no effect.
- R10: Codes 14 and 15 return a zero result with the overflow flag 0.
- R11: Result and flag are registered. Values on the inputs before a rising clock edge appear on the outputs after that edge. An active-low asynchronous reset clears both outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation code (0..15) |
| opnd_a | input | 32 | Operand A; supplies the variable shift count in A[4:0] |
| opnd_b | input | 32 | Operand B; the value that is shifted or placed in the upper half |
| shamt | input | 5 | Constant shift count |
| amt_from_reg | input | 1 | 1: shift count comes from A[4:0]; 0: it comes from shamt |
| result | output | 32 | Registered result |
| ovf | output | 1 | Registered overflow-trap flag |

## Verification
The case that is hardest to reach is a signed compare whose internal subtraction overflows. Here the sign bit of the difference gives the wrong answer unless it is corrected by the overflow term. The stimulus forces this case with operand pairs at opposite extremes of the signed range, such as 0x80000000 against 1 and 0x7FFFFFFF against 0xFFFFFFFF. It also runs the same pairs through the unsigned compare, where the answer is the opposite. For the count-source selection, the stimulus loads A with set upper bits and gives the constant input a different count. This way a shift by the wrong count, or a shift that depends on the wrong bits, shows up in the result.

// File: rtl/risc_alu_pkg.sv
package risc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDU = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBU = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOR  = 4'd7,
        OP_SLT  = 4'd8,
        OP_SLTU = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12,
        OP_LUI  = 4'd13
    } alu_op_e;

    // Low two bits of the logic codes pick the bitwise function.
    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2,
        LG_NOR = 2'd3
    } logic_fn_e;

endpackage

// File: rtl/risc_alu_addsub.sv
module risc_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             v_flag,
    output logic             lt_signed,
    output logic             lt_unsigned
);
    logic [WIDTH-1:0] b_eff;
    logic             carry_out;

    always_comb begin
        b_eff                = sub ? ~b : b;
        {carry_out, sum}     = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
        // Signed overflow: operands agree in sign, result disagrees.
        v_flag               = (a[WIDTH-1] == b_eff[WIDTH-1]) && (sum[WIDTH-1] != a[WIDTH-1]);
        // Sign of the true difference; corrected by the overflow term.
        lt_signed            = sum[WIDTH-1] ^ v_flag;
        // A borrow shows up as a missing carry in A + ~B + 1.
        lt_unsigned          = sub & ~carry_out;
    end
endmodule

// File: rtl/risc_alu_logic.sv
module risc_alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       fn,
    output logic [WIDTH-1:0] y
);
    import risc_alu_pkg::*;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign y[i] = (fn == LG_AND) ? (a[i] & b[i]) :
                      (fn == LG_OR)  ? (a[i] | b[i]) :
                      (fn == LG_XOR) ? (a[i] ^ b[i]) :
                                       ~(a[i] | b[i]);
    end
endmodule

// File: rtl/risc_alu_shift.sv
module risc_alu_shift #(
    parameter int WIDTH = 32,
    parameter int SHW   = 5
) (
    input  logic [WIDTH-1:0] value,
    input  logic [SHW-1:0]   amount,
    input  logic             go_left,
    input  logic             arith,
    output logic [WIDTH-1:0] shifted
);
    logic [WIDTH-1:0] value_rev;
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] last_rev;
    logic             fill;
    logic [WIDTH-1:0] stage [SHW+1];

    // A left shift is a right shift of the bit-reversed word.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign value_rev[i] = value[WIDTH-1-i];
        assign last_rev[i]  = stage[SHW][WIDTH-1-i];
    end

    assign src      = go_left ? value_rev : value;
    assign fill     = arith & ~go_left & value[WIDTH-1];
    assign stage[0] = src;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amount[s] ? {{STEP{fill}}, stage[s][WIDTH-1:STEP]} : stage[s];
    end

    assign shifted = go_left ? last_rev : stage[SHW];
endmodule

// File: rtl/risc_alu.sv
module risc_alu #(
    parameter int WIDTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [3:0]               op_sel,
    input  logic [WIDTH-1:0]         opnd_a,
    input  logic [WIDTH-1:0]         opnd_b,
    input  logic [$clog2(WIDTH)-1:0] shamt,
    input  logic                     amt_from_reg,
    output logic [WIDTH-1:0]         result,
    output logic                     ovf
);
    import risc_alu_pkg::*;

    localparam int SHW  = $clog2(WIDTH);
    localparam int HALF = WIDTH / 2;

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             ovf;
    } alu_out_t;

    alu_out_t out_d, out_q;

    logic             sub_en;
    logic [WIDTH-1:0] sum;
    logic             v_flag, lt_s, lt_u;
    logic [WIDTH-1:0] logic_y;
    logic [SHW-1:0]   shift_amt;
    logic             shl_en, sra_en;
    logic [WIDTH-1:0] shift_y;

    assign sub_en    = (op_sel == OP_SUB) || (op_sel == OP_SUBU) ||
                       (op_sel == OP_SLT) || (op_sel == OP_SLTU);
    assign shift_amt = amt_from_reg ? opnd_a[SHW-1:0] : shamt;
    assign shl_en    = (op_sel == OP_SLL);
    assign sra_en    = (op_sel == OP_SRA);

    risc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a          (opnd_a),
        .b          (opnd_b),
        .sub        (sub_en),
        .sum        (sum),
        .v_flag     (v_flag),
        .lt_signed  (lt_s),
        .lt_unsigned(lt_u)
    );

    risc_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a (opnd_a),
        .b (opnd_b),
        .fn(op_sel[1:0]),
        .y (logic_y)
    );

    risc_alu_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
        .value  (opnd_b),
        .amount (shift_amt),
        .go_left(shl_en),
        .arith  (sra_en),
        .shifted(shift_y)
    );

    always_comb begin
        out_d = '0;
        case (op_sel)
            OP_ADD, OP_SUB: begin
                out_d.res = sum;
                out_d.ovf = v_flag;
            end
            OP_ADDU, OP_SUBU:               out_d.res    = sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:  out_d.res    = logic_y;
            OP_SLT:                         out_d.res[0] = lt_s;
            OP_SLTU:                        out_d.res[0] = lt_u;
            OP_SLL, OP_SRL, OP_SRA:         out_d.res    = shift_y;
            OP_LUI:                         out_d.res    = {opnd_b[HALF-1:0], {(WIDTH-HALF){1'b0}}};
            default:                        out_d        = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result = out_q.res;
    assign ovf    = out_q.ovf;
endmodule

// File: rtl/risc_alu_chk.sv
module risc_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [3:0]               op_sel,
    input logic [WIDTH-1:0]         opnd_a,
    input logic [WIDTH-1:0]         opnd_b,
    input logic [$clog2(WIDTH)-1:0] shamt,
    input logic                     amt_from_reg,
    input logic [WIDTH-1:0]         result,
    input logic                     ovf
);
    localparam int HALF = WIDTH / 2;

    // Set once one edge has been taken out of reset, so $past refers to real inputs.
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_sel) == 4'd1 || $past(op_sel) == 4'd3) |-> !ovf);

    // R1
    add_ovf_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_sel) == 4'd0 && ovf |-> $past(opnd_a[WIDTH-1]) == $past(opnd_b[WIDTH-1]));

    // R4
    nor_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_sel) == 4'd7 |-> result == ~($past(opnd_a) | $past(opnd_b)));

    // R5
    slt_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ($past(op_sel) == 4'd8 || $past(op_sel) == 4'd9) |-> result[WIDTH-1:1] == '0 && !ovf);

    // R9
    upper_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_sel) == 4'd13 |-> result == {$past(opnd_b[HALF-1:0]), {(WIDTH-HALF){1'b0}}});

    // R10
    unused_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(op_sel) >= 4'd14 |-> result == '0 && !ovf);

    // R11
    ovf_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && ovf |-> $past(op_sel) == 4'd0 || $past(op_sel) == 4'd2);
endmodule

bind risc_alu risc_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_sel      (op_sel),
    .opnd_a      (opnd_a),
    .opnd_b      (opnd_b),
    .shamt       (shamt),
    .amt_from_reg(amt_from_reg),
    .result      (result),
    .ovf         (ovf)
);

// File: tb/sim_risc_alu.sv
module sim_risc_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt = '0;
    logic        amt_from_reg = 1'b0;
    logic [31:0] result;
    logic        ovf;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    risc_alu u0 (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .shamt(shamt), .amt_from_reg(amt_from_reg),
        .result(result), .ovf(ovf)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive on a falling edge, let one rising edge register it, sample on the next falling edge.
    task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] sh, input logic ur);
        @(negedge clk);
        op_sel = op; opnd_a = a; opnd_b = b; shamt = sh; amt_from_reg = ur;
        @(negedge clk);
    endtask

    function automatic logic sovf_add(input logic [31:0] a, input logic [31:0] b);
        longint s = longint'($signed(a)) + longint'($signed(b));
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    function automatic logic sovf_sub(input logic [31:0] a, input logic [31:0] b);
        longint s = longint'($signed(a)) - longint'($signed(b));
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    task automatic t_reset;
        check("R11 reset result", result, 32'h0);
        check("R11 reset ovf", {31'b0, ovf}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        op_sel = 4'd1; opnd_a = 32'd5; opnd_b = 32'd7;
        #2;
        check("R11 output holds before edge", result, 32'h0);
        @(negedge clk);
        check("R11 registered after edge", result, 32'd12);
    endtask

    task automatic t_add;
        logic [31:0] pa [4] = '{32'd10, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
        logic [31:0] pb [4] = '{32'd20, 32'd1, 32'h80000000, 32'h00000001};
        for (int i = 0; i < 4; i++) begin
            run(4'd0, pa[i], pb[i], 5'd0, 1'b0);
            check("R1 add sum", result, pa[i] + pb[i]);
            check("R1 add ovf", {31'b0, ovf}, {31'b0, sovf_add(pa[i], pb[i])});
        end
    endtask

    task automatic t_sub;
        logic [31:0] pa [4] = '{32'd50, 32'h80000000, 32'h7FFFFFFF, 32'd3};
        logic [31:0] pb [4] = '{32'd8, 32'd1, 32'hFFFFFFFF, 32'd9};
        for (int i = 0; i < 4; i++) begin
            run(4'd2, pa[i], pb[i], 5'd0, 1'b0);
            check("R2 sub diff", result, pa[i] - pb[i]);
            check("R2 sub ovf", {31'b0, ovf}, {31'b0, sovf_sub(pa[i], pb[i])});
        end
    endtask

    task automatic t_unsigned;
        run(4'd1, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b0);
        check("R3 addu value", result, 32'h80000000);
        check("R3 addu no ovf", {31'b0, ovf}, 32'h0);
        run(4'd3, 32'h80000000, 32'd1, 5'd0, 1'b0);
        check("R3 subu value", result, 32'h7FFFFFFF);
        check("R3 subu no ovf", {31'b0, ovf}, 32'h0);
    endtask

    task automatic t_logic;
        logic [31:0] a = 32'hF0F0_3C3C;
        logic [31:0] b = 32'hFF00_0FF0;
        run(4'd4, a, b, 5'd0, 1'b0); check("R4 and", result, a & b);
        run(4'd5, a, b, 5'd0, 1'b0); check("R4 or",  result, a | b);
        run(4'd6, a, b, 5'd0, 1'b0); check("R4 xor", result, a ^ b);
        run(4'd7, a, b, 5'd0, 1'b0); check("R4 nor", result, ~(a | b));
        run(4'd7, 32'h0, 32'h0, 5'd0, 1'b0); check("R4 nor zeros", result, 32'hFFFFFFFF);
    endtask

    task automatic t_compare;
        run(4'd8, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b0); check("R6 slt -1<1", result, 32'd1);
        run(4'd9, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b0); check("R6 sltu max<1", result, 32'd0);
        run(4'd8, 32'h80000000, 32'd1, 5'd0, 1'b0); check("R5 slt min<1 ovf case", result, 32'd1);
        run(4'd8, 32'h7FFFFFFF, 32'hFFFFFFFF, 5'd0, 1'b0); check("R5 slt max<-1 ovf case", result, 32'd0);
        run(4'd8, 32'd4, 32'd4, 5'd0, 1'b0); check("R5 slt equal", result, 32'd0);
        run(4'd9, 32'd2, 32'hFFFFFFF0, 5'd0, 1'b0); check("R6 sltu small<big", result, 32'd1);
        run(4'd9, 32'h80000000, 32'd1, 5'd0, 1'b0); check("R6 sltu min vs 1", result, 32'd0);
    endtask

    task automatic t_shift;
        logic [31:0] v = 32'h8421_F00D;
        for (int s = 0; s < 32; s += 7) begin
            run(4'd10, 32'h0, v, 5'(s), 1'b0); check("R7 sll", result, v << s);
            run(4'd11, 32'h0, v, 5'(s), 1'b0); check("R7 srl", result, v >> s);
            run(4'd12, 32'h0, v, 5'(s), 1'b0); check("R7 sra", result, 32'($signed(v) >>> s));
        end
        run(4'd12, 32'h0, 32'h7000_0000, 5'd31, 1'b0); check("R7 sra positive", result, 32'h0);
        run(4'd12, 32'h0, 32'h8000_0000, 5'd31, 1'b0); check("R7 sra negative", result, 32'hFFFFFFFF);
    endtask

    task automatic t_amount_source;
        run(4'd10, 32'hFFFF_FFE3, 32'h1, 5'd20, 1'b1);
        check("R8 reg amount uses A[4:0]", result, 32'h8);
        run(4'd11, 32'h1234_5604, 32'hF000_0000, 5'd1, 1'b1);
        check("R8 reg amount srl", result, 32'h0F00_0000);
        run(4'd10, 32'hFFFF_FFE3, 32'h1, 5'd20, 1'b0);
        check("R8 constant amount", result, 32'h0010_0000);
    endtask

    task automatic t_upper;
        run(4'd13, 32'hDEAD_BEEF, 32'hFFFF_A5C3, 5'd0, 1'b0);
        check("R9 upper placement", result, 32'hA5C3_0000);
        check("R9 no ovf", {31'b0, ovf}, 32'h0);
    endtask

    task automatic t_unused;
        run(4'd14, 32'h7FFFFFFF, 32'd1, 5'd3, 1'b0);
        check("R10 code 14 result", result, 32'h0);
        check("R10 code 14 ovf", {31'b0, ovf}, 32'h0);
        run(4'd15, 32'hFFFFFFFF, 32'hFFFFFFFF, 5'd3, 1'b1);
        check("R10 code 15 result", result, 32'h0);
        check("R10 code 15 ovf", {31'b0, ovf}, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_add();
        t_sub();
        t_unsigned();
        t_logic();
        t_compare();
        t_shift();
        t_amount_source();
        t_upper();
        t_unused();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule